// File: doc/BRIEF.md
# Interleaved Multi-Phase PWM Timer

This block drives the switches of an interleaved multi-phase power converter. A master counter sets the switching period and holds one phase point for each channel after the first. Channel 0 restarts when the master counter wraps to zero. Every other channel restarts when the master counter equals its own phase point. With phase points at one third and two thirds of the period, three channels run 120 degrees apart. Each channel has a slave counter that restarts at 0 on its event and stops once it reaches its own slave period. The channel output goes high when the channel restarts. It goes low when the slave counter reaches the channel's duty value, so each channel sets its own duty.

Each channel also raises a one-cycle pulse when its slave counter reaches a trigger compare value. The per-channel pulses are ORed into one conversion-trigger line. Because the channels are phase-shifted, one conversion channel can sample the whole converter. Software writes all timing values into shadow registers. The running copies take those values only at the master wrap, or on every cycle while the timer is stopped.

Top module: `ilv_pwm_top`

## Requirements
- R1: While running, the master counter counts 0, 1, …, P−1 and returns to 0, where the period P is the master period register value plus 1. The cycle in which the master counter equals the period register is the wrap cycle.
- R2: Channel 0 restarts in each cycle where the master counter is 0. Channel k (k ≥ 1) restarts in each cycle where the master counter equals master phase point k, so the phase spacing between channels is set by those points.
- R3: If a channel restarts in cycle E and its duty value D satisfies 0 < D < its slave period, its output is high in cycles E+1 through E+D and low from E+D+1 until the cycle after its next restart.
- R4: A channel whose duty value is 0 keeps its output low.
- R5: A channel whose duty value is at or above its slave period stays high from the cycle after its first restart onward.
- R6: A channel's slave counter reads 0 in cycle E+1 and counts up until it equals the slave period, where it holds. The channel produces a trigger pulse of one cycle in cycle E+1+T, where T is its trigger compare. If T is greater than the slave period, the channel never produces a trigger.
- R7: The trigger output is the OR of all per-channel trigger pulses.
- R8: While running, a register write takes effect in the cycle after the next wrap cycle. The output in the cycle after that is the first one built from the new value.
- R9: Bit 0 of the control register starts and stops the timer. When the timer is stopped, the master counter is held at 0 and the outputs are low from the second cycle after the stop write. When the timer starts, the first running cycle is a channel-0 restart.
- R10: The register addresses are: 0 control, 1 master period, 2 through NPH master phase points 1 through NPH−1, and NPH+1+3k+{0,1,2} for the slave period, duty and trigger compare of channel k.
- R11: Reset clears every register to 0, stops the timer and drives all outputs low.
- R12: A channel whose phase point is above the master period never restarts, and its output stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | clog2(4·NPH+1) | Register address (see R10) |
| cfg_wdata | input | CW | Register write data |
| pwm_out | output | NPH | Channel outputs, bit k is channel k |
| adc_trig | output | 1 | Merged conversion trigger pulse |

## Verification
The assertions check the following on every cycle:
- The master counter stays within its period and returns to 0 after the wrap cycle.
- A channel's slave counter reads 0 after its restart and holds once it saturates.
- A high output always comes from a nonzero duty value.
- The running copies do not change between wraps.
- The outputs stay quiet after a stop.

Only the bench scenarios can show the exact phase positions, pulse widths and trigger cycles, checked against arithmetic over many periods, duty values and phase points. The same applies to the cycle in which a write made while running first shows at an output.

// File: rtl/ilv_pwm_pkg.sv
// Shared constants for the interleaved PWM timer: register address layout
// and the per-channel register field selector.
package ilv_pwm_pkg;

    localparam int CTRL_ADDR = 0;
    localparam int MPER_ADDR = 1;
    localparam int MCMP_BASE = 2;
    localparam int SL_STRIDE = 3;

    typedef enum logic [1:0] {
        SL_PER  = 2'd0,
        SL_DUTY = 2'd1,
        SL_TRIG = 2'd2
    } sl_reg_e;

    // Address of one slave-channel field for a timer with nph channels.
    function automatic int sl_addr(int nph, int ch, sl_reg_e fld);
        return nph + 1 + SL_STRIDE * ch + int'(fld);
    endfunction

endpackage

// File: rtl/ilv_cfg_regs.sv
// Register file of the interleaved PWM timer.
// Holds the run bit, the shadow copies written by software and the active
// copies used by the counters. Active copies load from the shadows on every
// cycle while stopped and only at the master wrap while running.
// Assumes addresses follow the package layout; unknown addresses are ignored.
module ilv_cfg_regs
    import ilv_pwm_pkg::*;
#(
    parameter int NPH = 3,
    parameter int CW  = 16,
    parameter int AW  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [AW-1:0]           addr,
    input  logic [CW-1:0]           wdata,
    input  logic                    wrap,
    output logic                    run,
    output logic [CW-1:0]           mper,
    output logic [NPH-1:0][CW-1:0]  phase_pt,
    output logic [NPH-1:0][CW-1:0]  sper,
    output logic [NPH-1:0][CW-1:0]  duty,
    output logic [NPH-1:0][CW-1:0]  tcmp
);

    logic [CW-1:0]          sh_mper;
    logic [NPH-1:0][CW-1:0] sh_pt;
    logic [NPH-1:0][CW-1:0] sh_sper;
    logic [NPH-1:0][CW-1:0] sh_duty;
    logic [NPH-1:0][CW-1:0] sh_tcmp;
    logic                   load;

    assign load = !run || wrap;

    // Run bit: written through the control address.
    always_ff @(posedge clk) begin : run_reg
        if (!rst_n) begin
            run <= 1'b0;
        end else if (we && addr == AW'(CTRL_ADDR)) begin
            run <= wdata[0];
        end
    end

    // Shadow registers: capture software writes by address.
    always_ff @(posedge clk) begin : shadow_wr
        if (!rst_n) begin
            sh_mper <= '0;
            for (int k = 0; k < NPH; k++) begin
                sh_pt[k]   <= '0;
                sh_sper[k] <= '0;
                sh_duty[k] <= '0;
                sh_tcmp[k] <= '0;
            end
        end else if (we) begin
            if (addr == AW'(MPER_ADDR)) begin
                sh_mper <= wdata;
            end
            for (int k = 1; k < NPH; k++) begin
                if (addr == AW'(MCMP_BASE + k - 1)) begin
                    sh_pt[k] <= wdata;
                end
            end
            for (int k = 0; k < NPH; k++) begin
                if (addr == AW'(sl_addr(NPH, k, SL_PER))) begin
                    sh_sper[k] <= wdata;
                end
                if (addr == AW'(sl_addr(NPH, k, SL_DUTY))) begin
                    sh_duty[k] <= wdata;
                end
                if (addr == AW'(sl_addr(NPH, k, SL_TRIG))) begin
                    sh_tcmp[k] <= wdata;
                end
            end
        end
    end

    // Active registers: transfer from the shadows at a safe point.
    always_ff @(posedge clk) begin : active_load
        if (!rst_n) begin
            mper <= '0;
            for (int k = 0; k < NPH; k++) begin
                phase_pt[k] <= '0;
                sper[k]     <= '0;
                duty[k]     <= '0;
                tcmp[k]     <= '0;
            end
        end else if (load) begin
            mper <= sh_mper;
            for (int k = 0; k < NPH; k++) begin
                phase_pt[k] <= sh_pt[k];
                sper[k]     <= sh_sper[k];
                duty[k]     <= sh_duty[k];
                tcmp[k]     <= sh_tcmp[k];
            end
        end
    end

    // R8
    active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !wrap) |=> ($stable(mper) && $stable(phase_pt) && $stable(sper)
                            && $stable(duty) && $stable(tcmp)));

endmodule

// File: rtl/ilv_master_cnt.sv
// Master counter of the interleaved PWM timer.
// Counts 0..mper while running and wraps to 0; held at 0 while stopped.
// Raises one restart event per channel: channel 0 on count 0, channel k on
// count == phase_pt[k]. Assumes phase_pt[0] is 0.
module ilv_master_cnt #(
    parameter int NPH = 3,
    parameter int CW  = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    run,
    input  logic [CW-1:0]           mper,
    input  logic [NPH-1:0][CW-1:0]  phase_pt,
    output logic [NPH-1:0]          evt,
    output logic                    wrap
);

    logic [CW-1:0] mcnt;

    assign wrap = run && (mcnt == mper);

    // Period counter: step, wrap at the period value, clear when stopped.
    always_ff @(posedge clk) begin : period_cnt
        if (!rst_n) begin
            mcnt <= '0;
        end else if (!run || wrap) begin
            mcnt <= '0;
        end else begin
            mcnt <= mcnt + 1'b1;
        end
    end

    // Phase decode: one restart event per channel at its phase point.
    always_comb begin : phase_decode
        for (int k = 0; k < NPH; k++) begin
            evt[k] = run && (mcnt == phase_pt[k]);
        end
    end

    // R1
    mcnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (mcnt <= mper));

    // R1
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && mcnt == mper) |=> (mcnt == '0));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (mcnt == '0));

endmodule

// File: rtl/ilv_slave_ch.sv
// One slave channel of the interleaved PWM timer.
// Restarts its counter at 0 on the master event, then counts up and
// saturates at the slave period. The output is set by the restart and
// cleared when the count reaches the duty value. A one-cycle trigger fires
// when the count arrives at the trigger compare.
// Assumes the active configuration is stable between master wraps.
module ilv_slave_ch #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          evt,
    input  logic [CW-1:0] sper,
    input  logic [CW-1:0] duty,
    input  logic [CW-1:0] tcmp,
    output logic          pwm,
    output logic          trig
);

    logic [CW-1:0] scnt;
    logic [CW-1:0] scnt_nx;
    logic          armed;
    logic          armed_nx;
    logic          moved;
    logic          pwm_nx;
    logic          trig_nx;

    // Next-state logic for counter, output level and trigger pulse.
    always_comb begin : next_state
        armed_nx = run && (armed || evt);
        if (evt) begin
            scnt_nx = '0;
        end else if (scnt < sper) begin
            scnt_nx = scnt + 1'b1;
        end else begin
            scnt_nx = scnt;
        end
        moved   = evt || (scnt_nx != scnt);
        pwm_nx  = armed_nx && (duty != '0) && ((scnt_nx < duty) || (duty >= sper));
        trig_nx = armed_nx && moved && (scnt_nx == tcmp);
    end

    // State registers: counter, arm flag and registered outputs.
    always_ff @(posedge clk) begin : state_regs
        if (!rst_n) begin
            scnt  <= '0;
            armed <= 1'b0;
            pwm   <= 1'b0;
            trig  <= 1'b0;
        end else begin
            scnt  <= scnt_nx;
            armed <= armed_nx;
            pwm   <= pwm_nx;
            trig  <= trig_nx;
        end
    end

    // R6
    restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> (scnt == '0));

    // R6
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt && scnt == sper) |=> (scnt == $past(scnt)));

    // R4
    zero_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwm |-> ($past(duty) != '0));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!pwm && !trig));

endmodule

// File: rtl/ilv_pwm_top.sv
// Top of the interleaved multi-phase PWM timer.
// Ties the register file, the master counter and NPH slave channels
// together and ORs the per-channel trigger pulses into one line.
// Assumes software programs the phase points inside the master period.
module ilv_pwm_top #(
    parameter int NPH = 3,
    parameter int CW  = 16,
    localparam int AW = $clog2(4 * NPH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic [AW-1:0]  cfg_addr,
    input  logic [CW-1:0]  cfg_wdata,
    output logic [NPH-1:0] pwm_out,
    output logic           adc_trig
);

    logic                   run;
    logic                   wrap;
    logic [CW-1:0]          mper;
    logic [NPH-1:0][CW-1:0] phase_pt;
    logic [NPH-1:0][CW-1:0] sper;
    logic [NPH-1:0][CW-1:0] duty;
    logic [NPH-1:0][CW-1:0] tcmp;
    logic [NPH-1:0]         evt;
    logic [NPH-1:0]         trig_v;

    ilv_cfg_regs #(.NPH(NPH), .CW(CW), .AW(AW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .wrap     (wrap),
        .run      (run),
        .mper     (mper),
        .phase_pt (phase_pt),
        .sper     (sper),
        .duty     (duty),
        .tcmp     (tcmp)
    );

    ilv_master_cnt #(.NPH(NPH), .CW(CW)) u_master (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .mper     (mper),
        .phase_pt (phase_pt),
        .evt      (evt),
        .wrap     (wrap)
    );

    for (genvar g = 0; g < NPH; g++) begin : g_ch
        ilv_slave_ch #(.CW(CW)) u_ch (
            .clk   (clk),
            .rst_n (rst_n),
            .run   (run),
            .evt   (evt[g]),
            .sper  (sper[g]),
            .duty  (duty[g]),
            .tcmp  (tcmp[g]),
            .pwm   (pwm_out[g]),
            .trig  (trig_v[g])
        );
    end

    assign adc_trig = |trig_v;

endmodule

// File: tb/ilv_pwm_top_tb.sv
module ilv_pwm_top_tb;

    localparam int NPH = 3;
    localparam int CW  = 16;
    localparam int AW  = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cfg_we = 1'b0;
    logic [AW-1:0]  cfg_addr = '0;
    logic [CW-1:0]  cfg_wdata = '0;
    logic [NPH-1:0] pwm_out;
    logic           adc_trig;

    int nvec = 0;
    int nfail = 0;
    int jc = 0;

    // reference configuration
    int mper_m;
    int ph_m [NPH];
    int sper_m [NPH];
    int dold_m [NPH];
    int dnew_m [NPH];
    int tcmp_m [NPH];
    int sw_j;

    ilv_pwm_top #(.NPH(NPH), .CW(CW)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .pwm_out   (pwm_out),
        .adc_trig  (adc_trig)
    );

    always #4 clk = ~clk;

    function automatic bit exp_pwm(int k, int j);
        int d, s, du, p;
        p = mper_m + 1;
        if (ph_m[k] > mper_m || j - 1 < ph_m[k]) return 1'b0;
        d  = (j - 1 - ph_m[k]) % p;
        s  = (d < sper_m[k]) ? d : sper_m[k];
        du = (j - 1 < sw_j) ? dold_m[k] : dnew_m[k];
        return (du != 0) && ((s < du) || (du >= sper_m[k]));
    endfunction

    function automatic bit exp_trig(int k, int j);
        int d, p;
        p = mper_m + 1;
        if (ph_m[k] > mper_m || j - 1 < ph_m[k]) return 1'b0;
        d = (j - 1 - ph_m[k]) % p;
        return (d == tcmp_m[k]) && (tcmp_m[k] <= sper_m[k]);
    endfunction

    function automatic string pwm_tag(int k, int j);
        int du;
        du = (j - 1 < sw_j) ? dold_m[k] : dnew_m[k];
        if (ph_m[k] > mper_m) return "R12";
        if (du == 0) return "R4";
        if (du >= sper_m[k]) return "R5";
        return "R3";
    endfunction

    // compare outputs of interval j against the model
    task automatic check_cycle(string scen, int j);
        bit et;
        et = 1'b0;
        for (int k = 0; k < NPH; k++) begin
            nvec++;
            if (pwm_out[k] !== exp_pwm(k, j)) begin
                nfail++;
                $display("FAIL %s/%s ch%0d cycle %0d: actual %0b expected %0b",
                         scen, pwm_tag(k, j), k, j, pwm_out[k], exp_pwm(k, j));
            end
            et = et | exp_trig(k, j);
        end
        nvec++;
        if (adc_trig !== et) begin
            nfail++;
            $display("FAIL %s/R6/R7 trigger cycle %0d: actual %0b expected %0b",
                     scen, j, adc_trig, et);
        end
    endtask

    task automatic wr(int a, int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = AW'(a); cfg_wdata = CW'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic setup(int mp, int p1, int p2, int sp0, int sp1, int sp2,
                         int d0, int d1, int d2, int t0, int t1, int t2);
        mper_m = mp; ph_m[0] = 0; ph_m[1] = p1; ph_m[2] = p2;
        sper_m[0] = sp0; sper_m[1] = sp1; sper_m[2] = sp2;
        dold_m[0] = d0; dold_m[1] = d1; dold_m[2] = d2;
        tcmp_m[0] = t0; tcmp_m[1] = t1; tcmp_m[2] = t2;
        for (int k = 0; k < NPH; k++) dnew_m[k] = dold_m[k];
        sw_j = 1 << 30;
        // R10 register layout
        wr(1, mp); wr(2, p1); wr(3, p2);
        for (int k = 0; k < NPH; k++) begin
            wr(4 + 3 * k, sper_m[k]);
            wr(5 + 3 * k, dold_m[k]);
            wr(6 + 3 * k, tcmp_m[k]);
        end
    endtask

    task automatic start(string scen);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = '0; cfg_wdata = CW'(1);
        @(negedge clk);
        cfg_we = 1'b0;
        jc = 0;
        check_cycle(scen, 0);
    endtask

    task automatic step_to(string scen, int jend);
        while (jc < jend) begin
            @(negedge clk);
            cfg_we = 1'b0;
            jc++;
            check_cycle(scen, jc);
        end
    endtask

    // R9: stop and confirm quiet outputs
    task automatic stop();
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = '0; cfg_wdata = '0;
        @(negedge clk);
        cfg_we = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            nvec++;
            if (pwm_out !== '0 || adc_trig !== 1'b0) begin
                nfail++;
                $display("FAIL R9 stopped outputs: actual %b/%b expected 000/0",
                         pwm_out, adc_trig);
            end
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL R11 watchdog expired: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        nvec++;
        if (pwm_out !== '0 || adc_trig !== 1'b0) begin
            nfail++;
            $display("FAIL R11 reset outputs: actual %b/%b expected 000/0", pwm_out, adc_trig);
        end
        // R11 run on reset values: every register zero
        mper_m = 0; sw_j = 1 << 30;
        for (int k = 0; k < NPH; k++) begin
            ph_m[k] = 0; sper_m[k] = 0; dold_m[k] = 0; dnew_m[k] = 0; tcmp_m[k] = 0;
        end
        start("R11");
        step_to("R11", 8);
        stop();

        // R10 sweep: 120 degree spacing, asymmetric channel values
        for (int d = 0; d < 10; d++) begin
            setup(8, 3, 6, 7, 7, 7, d, (d + 4) % 10, 9 - d,
                  d, (d + 2) % 10, (3 * d) % 10);
            start("R10");
            step_to("R10", 40);
            stop();
        end

        // R1 sweep over master periods
        for (int m = 0; m < 12; m++) begin
            setup(m, (m + 1) / 3, 2 * (m + 1) / 3, m, m, m,
                  (m + 1) / 2, m / 3, m + 1, m / 2, 0, m);
            start("R1");
            step_to("R1", 3 * (m + 1) + 6);
            stop();
        end

        // R2 sweep over phase points
        for (int p = 0; p < 7; p++) begin
            setup(6, p, 6 - p, 10, 10, 10, 2, 3, 4, 1, 2, 5);
            start("R2");
            step_to("R2", 25);
            stop();
        end

        // R12 phase point beyond the period
        setup(5, 2, 9, 4, 4, 4, 3, 3, 3, 1, 1, 1);
        start("R12");
        step_to("R12", 30);
        stop();

        // R8 duty change while running waits for the wrap
        setup(8, 3, 6, 8, 8, 8, 2, 5, 7, 4, 4, 4);
        start("R8");
        step_to("R8", 13);
        cfg_we = 1'b1; cfg_addr = AW'(5); cfg_wdata = CW'(6);
        dnew_m[0] = 6;
        begin
            int jw;
            jw = jc + 1 + (((mper_m - (jc + 1)) % (mper_m + 1)) + (mper_m + 1)) % (mper_m + 1);
            sw_j = jw + 1;
        end
        step_to("R8", 45);
        stop();

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule